// File: doc/BRIEF.md
# Flash Query Geometry Discovery Engine

This block probes a parallel NOR flash device sitting on a simple synchronous memory-style bus and learns its layout from the standard common flash interface query space. A single-cycle `start` pulse makes it reset the device, switch it into query mode and confirm the three-byte `QRY` signature. When the signature matches, it reads the command-set identifier, the typical and worst-case program and erase timeout exponents, the device size exponent and the erase-region table. It then returns the device to array mode with an exit write that depends on the command set.

The decoded results are a found/not-found pair, the command set, both timeouts converted into clock cycles, the size exponent, the region count and, for each region, its start offset, block count and block size. The erase-region table is stored up to `MAX_REGIONS` entries. Each bus transfer is a request that the engine holds until the device side acknowledges it, and read data is taken in the acknowledge cycle. With `WIDE16` set, every query offset is doubled to form the byte address. All query data is one byte wide.

Top module: `cfi_geom_probe`

## Requirements
- R1: After a start, the first two bus transfers are writes of 0xF0 at query offset 0x00 and then 0x98 at query offset 0x55. When WIDE16=1, the bus address of every access, read or write, is the query offset shifted left by one bit.
- R2: The bytes read at offsets 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59. On a mismatch the engine finishes with not_found=1 and found=0, and it issues no exit write. In that case cmdset, both timeouts, size_log2, region_cnt, region_err and all region fields read zero.
- R3: cmdset is the 16-bit little-endian value formed from offset 0x13 (low byte) and offset 0x14 (high byte).
- R4: prog_tmo_cyc equals CLK_PER_US shifted left by (byte 0x1F + byte 0x23). erase_tmo_cyc equals CLK_PER_MS shifted left by (byte 0x21 + byte 0x25). Either result is all ones when the true value does not fit in 64 bits.
- R5: size_log2 is the byte at offset 0x27. The region count is taken from the byte at offset 0x2C.
- R6: For region r, the 16-bit little-endian field at 0x2D+4r gives the block count minus one. The field at 0x2F+4r gives the block size in units of 256 bytes, where a value of zero means 128 bytes. The block count is a 17-bit field and the size is a 24-bit field, both stored in slot r.
- R7: The start offset of region r is the sum of block size times block count over regions 0 to r-1, so region 0 starts at 0. The sum is kept to OFS_W bits.
- R8: A region count above MAX_REGIONS is clamped to MAX_REGIONS, and region_err is raised. Region slots at or beyond region_cnt read zero.
- R9: The exit writes at offset 0x00 depend on the command set. Command set 2 gets 0xF0 and then 0xFF. Command sets 1 and 3 get 0xFF only. Any other command set gets no exit write.
- R10: busy rises in the cycle after an accepted start and falls together with a one-cycle done pulse. A start while busy is ignored.
- R11: A bus request keeps its address, write enable and write data unchanged until it is acknowledged.
- R12: After reset, busy, done, found, not_found and bus_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Signature matched on the last probe |
| not_found | output | 1 | Signature mismatch on the last probe |
| region_err | output | 1 | Region count exceeded MAX_REGIONS |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer accepted; read data valid |
| bus_rdata | input | 8 | Read data |
| cmdset | output | 16 | Command-set identifier |
| prog_tmo_cyc | output | 64 | Program timeout in cycles |
| erase_tmo_cyc | output | 64 | Erase timeout in cycles |
| size_log2 | output | 8 | Log2 of device size in bytes |
| region_cnt | output | $clog2(MAX_REGIONS+1) | Number of valid regions |
| rg_start | output | MAX_REGIONS*OFS_W | Region start offsets, slot r at bits r*OFS_W |
| rg_blocks | output | MAX_REGIONS*17 | Region block counts, slot r at bits r*17 |
| rg_bsize | output | MAX_REGIONS*24 | Region block sizes in bytes, slot r at bits r*24 |

## Verification
The bench uses WIDE16=1, MAX_REGIONS=8, OFS_W=48, CLK_PER_US=250 and CLK_PER_MS=250000. The wide setting makes the doubled addresses visible in the write log and in the read image lookup. The eight-slot table can be filled completely, and a count of ten reaches the clamp. The large millisecond constant lets moderate erase exponents overflow 64 bits, so saturation is reached without extreme table values. An acknowledge pattern with stalls holds requests across several cycles.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

    localparam int BLK_W = 17;
    localparam int BSZ_W = 24;

    localparam logic [7:0] CMD_ARRAY_A = 8'hF0;
    localparam logic [7:0] CMD_ARRAY_B = 8'hFF;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] OFS_ENTRY   = 8'h55;
    localparam logic [7:0] OFS_SIG     = 8'h10;
    localparam logic [7:0] OFS_RGN     = 8'h2D;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WR_RST, ST_WR_QRY, ST_RD_SIG, ST_RD_HDR,
        ST_RD_RGN, ST_EXIT_A, ST_EXIT_B, ST_FIN
    } probe_st_e;

    typedef struct packed {
        logic [BLK_W-1:0] blocks;
        logic [BSZ_W-1:0] bsize;
    } rgn_rec_t;

    function automatic logic [7:0] sig_byte(input logic [1:0] i);
        case (i)
            2'd0:    return 8'h51;
            2'd1:    return 8'h52;
            default: return 8'h59;
        endcase
    endfunction

    // Header byte order: cs lo, cs hi, prog typ, prog max, erase typ, erase max, size, count
    function automatic logic [7:0] hdr_off(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h13;
            3'd1:    return 8'h14;
            3'd2:    return 8'h1F;
            3'd3:    return 8'h23;
            3'd4:    return 8'h21;
            3'd5:    return 8'h25;
            3'd6:    return 8'h27;
            default: return 8'h2C;
        endcase
    endfunction

    function automatic logic [63:0] sat_shl(input logic [63:0] v, input logic [8:0] e);
        logic [127:0] w;
        if (e >= 9'd64) return (v == 64'd0) ? 64'd0 : '1;
        w = {64'd0, v} << e;
        return (w[127:64] != 64'd0) ? '1 : w[63:0];
    endfunction

endpackage

// File: rtl/cfi_addr_map.sv
module cfi_addr_map #(
    parameter int ADDR_W = 16,
    parameter bit WIDE16 = 1'b1
) (
    input  logic [7:0]        ofs,
    output logic [ADDR_W-1:0] addr
);
    generate
        if (WIDE16) begin : g_wide
            assign addr = ADDR_W'({ofs, 1'b0});
        end else begin : g_narrow
            assign addr = ADDR_W'(ofs);
        end
    endgenerate
endmodule

// File: rtl/cfi_tmo_conv.sv
module cfi_tmo_conv
    import cfi_probe_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int CLK_PER_MS = 250000
) (
    input  logic [7:0]  prog_typ,
    input  logic [7:0]  prog_max,
    input  logic [7:0]  erase_typ,
    input  logic [7:0]  erase_max,
    output logic [63:0] prog_cyc,
    output logic [63:0] erase_cyc
);
    logic [8:0] e_prog, e_erase;
    assign e_prog   = {1'b0, prog_typ} + {1'b0, prog_max};
    assign e_erase  = {1'b0, erase_typ} + {1'b0, erase_max};
    assign prog_cyc  = sat_shl(64'(CLK_PER_US), e_prog);
    assign erase_cyc = sat_shl(64'(CLK_PER_MS), e_erase);
endmodule

// File: rtl/cfi_region_acc.sv
module cfi_region_acc
    import cfi_probe_pkg::*;
#(
    parameter int MAX_REGIONS = 8,
    parameter int OFS_W       = 48,
    localparam int RIDX_W     = $clog2(MAX_REGIONS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [RIDX_W-1:0]            wr_idx,
    input  logic [15:0]                  fld_cnt,
    input  logic [15:0]                  fld_size,
    output logic [MAX_REGIONS*OFS_W-1:0] start_flat,
    output logic [MAX_REGIONS*BLK_W-1:0] blk_flat,
    output logic [MAX_REGIONS*BSZ_W-1:0] bsz_flat
);
    rgn_rec_t         rec_q   [MAX_REGIONS];
    logic [OFS_W-1:0] start_q [MAX_REGIONS];
    logic [OFS_W-1:0] run_q;

    logic [BLK_W-1:0] blocks_c;
    logic [BSZ_W-1:0] bsize_c;
    logic [OFS_W-1:0] span_c;

    assign blocks_c = BLK_W'(fld_cnt) + BLK_W'(1);
    assign bsize_c  = (fld_size == 16'd0) ? BSZ_W'(128) : {fld_size, 8'h00};
    assign span_c   = OFS_W'(blocks_c) * OFS_W'(bsize_c);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
            for (int i = 0; i < MAX_REGIONS; i++) begin
                rec_q[i]   <= '0;
                start_q[i] <= '0;
            end
        end else if (wr_en) begin
            rec_q[wr_idx]   <= '{blocks: blocks_c, bsize: bsize_c};
            start_q[wr_idx] <= run_q;
            run_q           <= run_q + span_c;
        end
    end

    generate
        for (genvar r = 0; r < MAX_REGIONS; r++) begin : g_flat
            assign start_flat[r*OFS_W +: OFS_W] = start_q[r];
            assign blk_flat[r*BLK_W +: BLK_W]   = rec_q[r].blocks;
            assign bsz_flat[r*BSZ_W +: BSZ_W]   = rec_q[r].bsize;
        end
    endgenerate
endmodule

// File: rtl/cfi_geom_probe.sv
module cfi_geom_probe
    import cfi_probe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter bit WIDE16      = 1'b1,
    parameter int MAX_REGIONS = 8,
    parameter int OFS_W       = 48,
    parameter int CLK_PER_US  = 250,
    parameter int CLK_PER_MS  = 250000,
    localparam int RIDX_W     = $clog2(MAX_REGIONS),
    localparam int CNT_W      = $clog2(MAX_REGIONS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         found,
    output logic                         not_found,
    output logic                         region_err,
    output logic                         bus_req,
    output logic                         bus_we,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic [7:0]                   bus_wdata,
    input  logic                         bus_ack,
    input  logic [7:0]                   bus_rdata,
    output logic [15:0]                  cmdset,
    output logic [63:0]                  prog_tmo_cyc,
    output logic [63:0]                  erase_tmo_cyc,
    output logic [7:0]                   size_log2,
    output logic [CNT_W-1:0]             region_cnt,
    output logic [MAX_REGIONS*OFS_W-1:0] rg_start,
    output logic [MAX_REGIONS*BLK_W-1:0] rg_blocks,
    output logic [MAX_REGIONS*BSZ_W-1:0] rg_bsize
);
    probe_st_e         state;
    logic [2:0]        idx;
    logic [RIDX_W-1:0] rgn;
    logic [7:0]        hdr_q [0:6];
    logic [7:0]        rb_q  [0:3];
    logic [CNT_W-1:0]  cnt_q;
    logic              sig_ok, found_q, nf_q, rerr_q;

    logic              xfer, over_c, acc_wr, acc_clr;
    logic [CNT_W-1:0]  cnt_eff_c;
    logic [7:0]        ofs_c;
    logic [15:0]       cs_c;
    logic [63:0]       prog_c, erase_c;
    logic [MAX_REGIONS*OFS_W-1:0] acc_start;
    logic [MAX_REGIONS*BLK_W-1:0] acc_blk;
    logic [MAX_REGIONS*BSZ_W-1:0] acc_bsz;

    assign cs_c      = {hdr_q[1], hdr_q[0]};
    assign xfer      = bus_req && bus_ack;
    assign over_c    = bus_rdata > 8'(MAX_REGIONS);
    assign cnt_eff_c = over_c ? CNT_W'(MAX_REGIONS) : bus_rdata[CNT_W-1:0];
    assign acc_clr   = (state == ST_IDLE) && start;
    assign acc_wr    = (state == ST_RD_RGN) && xfer && (idx == 3'd3);

    // Bus request decode
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = 8'h00;
        ofs_c     = 8'h00;
        case (state)
            ST_WR_RST: begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CMD_ARRAY_A; end
            ST_WR_QRY: begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CMD_QUERY; ofs_c = OFS_ENTRY; end
            ST_RD_SIG: begin bus_req = 1'b1; ofs_c = OFS_SIG + 8'(idx); end
            ST_RD_HDR: begin bus_req = 1'b1; ofs_c = hdr_off(idx); end
            ST_RD_RGN: begin bus_req = 1'b1; ofs_c = OFS_RGN + 8'({rgn, 2'b00}) + 8'(idx); end
            ST_EXIT_A: begin bus_req = (cs_c == 16'd2); bus_we = 1'b1; bus_wdata = CMD_ARRAY_A; end
            ST_EXIT_B: begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CMD_ARRAY_B; end
            default: ;
        endcase
    end

    cfi_addr_map #(.ADDR_W(ADDR_W), .WIDE16(WIDE16)) u_amap (
        .ofs (ofs_c),
        .addr(bus_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            rgn     <= '0;
            cnt_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sig_ok  <= 1'b0;
            found_q <= 1'b0;
            nf_q    <= 1'b0;
            rerr_q  <= 1'b0;
            for (int i = 0; i < 7; i++) hdr_q[i] <= '0;
            for (int i = 0; i < 4; i++) rb_q[i]  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    busy    <= 1'b1;
                    state   <= ST_WR_RST;
                    idx     <= '0;
                    rgn     <= '0;
                    cnt_q   <= '0;
                    sig_ok  <= 1'b0;
                    found_q <= 1'b0;
                    nf_q    <= 1'b0;
                    rerr_q  <= 1'b0;
                    for (int i = 0; i < 7; i++) hdr_q[i] <= '0;
                end
                ST_WR_RST: if (xfer) state <= ST_WR_QRY;
                ST_WR_QRY: if (xfer) begin state <= ST_RD_SIG; idx <= '0; end
                ST_RD_SIG: if (xfer) begin
                    if (bus_rdata != sig_byte(idx[1:0])) state <= ST_FIN;
                    else if (idx == 3'd2) begin
                        state  <= ST_RD_HDR;
                        idx    <= '0;
                        sig_ok <= 1'b1;
                    end else idx <= idx + 3'd1;
                end
                ST_RD_HDR: if (xfer) begin
                    if (idx == 3'd7) begin
                        cnt_q  <= cnt_eff_c;
                        rerr_q <= over_c;
                        idx    <= '0;
                        rgn    <= '0;
                        state  <= (cnt_eff_c == '0) ? ST_EXIT_A : ST_RD_RGN;
                    end else begin
                        hdr_q[idx] <= bus_rdata;
                        idx        <= idx + 3'd1;
                    end
                end
                ST_RD_RGN: if (xfer) begin
                    if (idx == 3'd3) begin
                        idx <= '0;
                        if ((CNT_W'(rgn) + CNT_W'(1)) == cnt_q) state <= ST_EXIT_A;
                        else rgn <= rgn + RIDX_W'(1);
                    end else begin
                        rb_q[idx[1:0]] <= bus_rdata;
                        idx            <= idx + 3'd1;
                    end
                end
                ST_EXIT_A: begin
                    if (cs_c == 16'd2) begin
                        if (xfer) state <= ST_EXIT_B;
                    end else if (cs_c == 16'd1 || cs_c == 16'd3) state <= ST_EXIT_B;
                    else state <= ST_FIN;
                end
                ST_EXIT_B: if (xfer) state <= ST_FIN;
                ST_FIN: begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    found_q <= sig_ok;
                    nf_q    <= !sig_ok;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    cfi_tmo_conv #(.CLK_PER_US(CLK_PER_US), .CLK_PER_MS(CLK_PER_MS)) u_tmo (
        .prog_typ (hdr_q[2]),
        .prog_max (hdr_q[3]),
        .erase_typ(hdr_q[4]),
        .erase_max(hdr_q[5]),
        .prog_cyc (prog_c),
        .erase_cyc(erase_c)
    );

    cfi_region_acc #(.MAX_REGIONS(MAX_REGIONS), .OFS_W(OFS_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (acc_clr),
        .wr_en     (acc_wr),
        .wr_idx    (rgn),
        .fld_cnt   ({rb_q[1], rb_q[0]}),
        .fld_size  ({bus_rdata, rb_q[2]}),
        .start_flat(acc_start),
        .blk_flat  (acc_blk),
        .bsz_flat  (acc_bsz)
    );

    // Results are published only for a matched signature
    assign found         = found_q;
    assign not_found     = nf_q;
    assign region_err    = found_q && rerr_q;
    assign cmdset        = found_q ? cs_c : 16'd0;
    assign prog_tmo_cyc  = found_q ? prog_c : 64'd0;
    assign erase_tmo_cyc = found_q ? erase_c : 64'd0;
    assign size_log2     = found_q ? hdr_q[6] : 8'd0;
    assign region_cnt    = found_q ? cnt_q : '0;
    assign rg_start      = found_q ? acc_start : '0;
    assign rg_blocks     = found_q ? acc_blk : '0;
    assign rg_bsize      = found_q ? acc_bsz : '0;
endmodule

// File: rtl/cfi_probe_chk.sv
module cfi_probe_chk #(
    parameter int ADDR_W      = 16,
    parameter int MAX_REGIONS = 8,
    localparam int CNT_W      = $clog2(MAX_REGIONS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              not_found,
    input logic              region_err,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack,
    input logic [15:0]       cmdset,
    input logic [CNT_W-1:0]  region_cnt
);
    p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_cmd_bytes_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (bus_wdata == 8'hF0 || bus_wdata == 8'h98 || bus_wdata == 8'hFF));

    p_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        region_err |-> (region_cnt == CNT_W'(MAX_REGIONS)));

    p_absent_r2: assert property (@(posedge clk) disable iff (rst)
        not_found |-> (!found && region_cnt == '0 && cmdset == 16'd0));
endmodule

bind cfi_geom_probe cfi_probe_chk #(.ADDR_W(ADDR_W), .MAX_REGIONS(MAX_REGIONS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .not_found (not_found),
    .region_err(region_err),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .cmdset    (cmdset),
    .region_cnt(region_cnt)
);

// File: tb/tb_cfi_geom_probe.sv
`timescale 1ns/1ps
module tb_cfi_geom_probe;
    localparam int ADDR_W = 16;
    localparam int MAXR   = 8;
    localparam int OFSW   = 48;
    localparam int CPU    = 250;
    localparam int CPM    = 250000;
    localparam int CNTW   = $clog2(MAXR + 1);

    typedef struct packed {
        logic        bad;
        logic        stall;
        logic [15:0] cs;
        logic [7:0]  wt, wm, et, em, sz, nr;
        logic [15:0] c0, s0, c1, s1;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0002, 8'd4,  8'd3,  8'd9,  8'd4, 8'h17, 8'd2,  16'h0007, 16'h0020, 16'h003E, 16'h0100},
        '{1'b0, 1'b1, 16'h0001, 8'd5,  8'd2,  8'd10, 8'd2, 8'h18, 8'd1,  16'h00FF, 16'h0000, 16'h0000, 16'h0000},
        '{1'b0, 1'b0, 16'h0003, 8'd0,  8'd0,  8'd0,  8'd0, 8'h10, 8'd0,  16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{1'b0, 1'b1, 16'h0204, 8'd1,  8'd1,  8'd1,  8'd1, 8'h1A, 8'd8,  16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000},
        '{1'b0, 1'b0, 16'h0002, 8'h20, 8'h20, 8'h30, 8'h08, 8'h19, 8'd10, 16'h0003, 16'h0040, 16'h0001, 16'h0002},
        '{1'b1, 1'b0, 16'h0002, 8'd4,  8'd3,  8'd9,  8'd4, 8'h17, 8'd2,  16'h0007, 16'h0020, 16'h003E, 16'h0100}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, found, not_found, region_err;
    logic bus_req, bus_we, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [15:0] cmdset;
    logic [63:0] prog_tmo_cyc, erase_tmo_cyc;
    logic [7:0] size_log2;
    logic [CNTW-1:0] region_cnt;
    logic [MAXR*OFSW-1:0] rg_start;
    logic [MAXR*17-1:0] rg_blocks;
    logic [MAXR*24-1:0] rg_bsize;

    always #2 clk = ~clk;

    logic [7:0] img [0:127];
    logic stall = 1'b0;
    int   cyc = 0;
    assign bus_rdata = img[bus_addr[7:1]];
    assign bus_ack   = bus_req && (!stall || (cyc % 3 == 0));

    logic              wclr = 1'b0;
    int                wcnt = 0;
    logic [ADDR_W-1:0] wa [0:15];
    logic [7:0]        wd [0:15];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wclr) wcnt = 0;
        else if (bus_req && bus_we && bus_ack) begin
            if (wcnt < 16) begin wa[wcnt] = bus_addr; wd[wcnt] = bus_wdata; end
            wcnt = wcnt + 1;
        end
    end

    cfi_geom_probe #(.ADDR_W(ADDR_W), .WIDE16(1'b1), .MAX_REGIONS(MAXR), .OFS_W(OFSW),
                     .CLK_PER_US(CPU), .CLK_PER_MS(CPM)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .found(found),
        .not_found(not_found), .region_err(region_err), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .cmdset(cmdset), .prog_tmo_cyc(prog_tmo_cyc), .erase_tmo_cyc(erase_tmo_cyc),
        .size_log2(size_log2), .region_cnt(region_cnt), .rg_start(rg_start),
        .rg_blocks(rg_blocks), .rg_bsize(rg_bsize));

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_tmo(input logic [63:0] base, input int e);
        if (e >= 64) return '1;
        if (e > 0 && (base >> (64 - e)) != 64'd0) return '1;
        return base << e;
    endfunction

    function automatic logic [15:0] fld_c(input vec_t v, input int r);
        return (r == 0) ? v.c0 : (r == 1) ? v.c1 : 16'(r);
    endfunction
    function automatic logic [15:0] fld_s(input vec_t v, input int r);
        return (r == 0) ? v.s0 : (r == 1) ? v.s1 : 16'(r);
    endfunction

    task automatic load_image(input vec_t v);
        for (int i = 0; i < 128; i++) img[i] = 8'h00;
        img[8'h10] = 8'h51; img[8'h11] = 8'h52; img[8'h12] = v.bad ? 8'h5A : 8'h59;
        img[8'h13] = v.cs[7:0]; img[8'h14] = v.cs[15:8];
        img[8'h1F] = v.wt; img[8'h23] = v.wm; img[8'h21] = v.et; img[8'h25] = v.em;
        img[8'h27] = v.sz; img[8'h2C] = v.nr;
        for (int r = 0; r < 10; r++) begin
            img[8'h2D + 4*r]     = fld_c(v, r)[7:0];
            img[8'h2D + 4*r + 1] = fld_c(v, r)[15:8];
            img[8'h2D + 4*r + 2] = fld_s(v, r)[7:0];
            img[8'h2D + 4*r + 3] = fld_s(v, r)[15:8];
        end
        stall = v.stall;
    endtask

    task automatic run_probe(output bit ok);
        @(negedge clk); wclr = 1'b1; start = 1'b1;
        @(negedge clk); wclr = 1'b0; start = 1'b0;
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) chk("R10 watchdog done", 64'd0, 64'd1);
    endtask

    task automatic check_result(input vec_t v);
        int eff;
        logic [63:0] run;
        logic [63:0] blk, bsz;
        int nx;
        eff = (v.nr > MAXR) ? MAXR : int'(v.nr);
        chk("R2 found", 64'(found), 64'(!v.bad));
        chk("R2 not_found", 64'(not_found), 64'(v.bad));
        chk("R3 cmdset", 64'(cmdset), v.bad ? 64'd0 : 64'(v.cs));
        chk("R4 prog timeout", prog_tmo_cyc, v.bad ? 64'd0 : exp_tmo(64'(CPU), int'(v.wt) + int'(v.wm)));
        chk("R4 erase timeout", erase_tmo_cyc, v.bad ? 64'd0 : exp_tmo(64'(CPM), int'(v.et) + int'(v.em)));
        chk("R5 size", 64'(size_log2), v.bad ? 64'd0 : 64'(v.sz));
        chk("R5 region count", 64'(region_cnt), v.bad ? 64'd0 : 64'(eff));
        chk("R8 region error", 64'(region_err), 64'(!v.bad && v.nr > MAXR));
        run = 64'd0;
        for (int r = 0; r < MAXR; r++) begin
            if (!v.bad && r < eff) begin
                blk = 64'(fld_c(v, r)) + 64'd1;
                bsz = (fld_s(v, r) == 16'd0) ? 64'd128 : 64'(fld_s(v, r)) * 64'd256;
                chk("R6 blocks", 64'(rg_blocks[r*17 +: 17]), blk);
                chk("R6 block size", 64'(rg_bsize[r*24 +: 24]), bsz);
                chk("R7 start offset", 64'(rg_start[r*OFSW +: OFSW]), 64'(run[OFSW-1:0]));
                run = run + blk * bsz;
            end else begin
                chk("R8 unused slot", 64'(rg_blocks[r*17 +: 17]) | 64'(rg_bsize[r*24 +: 24]) | 64'(rg_start[r*OFSW +: OFSW]), 64'd0);
            end
        end
        chk("R1 entry write 0", {32'd0, 8'(wa[0]), wd[0], 16'd0}, {32'd0, 8'h00, 8'hF0, 16'd0});
        chk("R1 entry write 1", {32'd0, 8'(wa[1]), wd[1], 16'd0}, {32'd0, 8'hAA, 8'h98, 16'd0});
        nx = v.bad ? 0 : (v.cs == 16'd2) ? 2 : (v.cs == 16'd1 || v.cs == 16'd3) ? 1 : 0;
        chk("R9 write count", 64'(wcnt), 64'(2 + nx));
        if (nx == 2) begin
            chk("R9 exit F0", {48'd0, 8'(wa[2]), wd[2]}, {48'd0, 8'h00, 8'hF0});
            chk("R9 exit FF", {48'd0, 8'(wa[3]), wd[3]}, {48'd0, 8'h00, 8'hFF});
        end else if (nx == 1) begin
            chk("R9 exit FF", {48'd0, 8'(wa[2]), wd[2]}, {48'd0, 8'h00, 8'hFF});
        end
    endtask

    initial begin
        bit ok;
        for (int i = 0; i < 128; i++) img[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", 64'(busy), 64'd0);
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 found", 64'(found), 64'd0);
        chk("R12 not_found", 64'(not_found), 64'd0);
        chk("R12 bus_req", 64'(bus_req), 64'd0);

        for (int k = 0; k < NV; k++) begin
            load_image(VECS[k]);
            run_probe(ok);
            if (ok) check_result(VECS[k]);
            @(negedge clk);
            chk("R10 done pulse", 64'(done), 64'd0);
            chk("R10 idle after done", 64'(busy), 64'd0);
        end

        // R10: busy timing and start while busy ignored
        load_image(VECS[0]);
        @(negedge clk); wclr = 1'b1; start = 1'b1;
        @(negedge clk); wclr = 1'b0; start = 1'b0;
        chk("R10 busy after start", 64'(busy), 64'd1);
        repeat (6) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        chk("R10 finished", 64'(ok), 64'd1);
        if (ok) check_result(VECS[0]);
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            chk("R10 no restart", 64'(busy), 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule